// File: doc/BRIEF.md
# Memory-Mapped Pointer Register Unit

This unit holds the address pointers of a small processor: one program counter, three stack pointers, two index pointers and two offsets. The arithmetic unit cannot reach them. Software reaches them only through a sixteen-word window in the data address space, using a chip-select, write-enable and read-enable interface with 16-bit data. The 20-bit pointers take two window slots each. The low slot holds bits 15..0 and the high slot holds bits 19..16.

The control sequencer drives the counting inputs. It advances the program counter by 0 to 3 in a cycle, and it steps any stack pointer up or down by one. It also picks an index pointer for address generation and can request that the index be offset. In that case the matching 16-bit offset, zero-extended, is added to the index to form the effective address. Pointer values are brought out continuously for the memory address path.

Top module: `ptr_reg_unit`

## Requirements
- R1: After reset every pointer and offset register reads as zero, and `pc_q`, `sp_q` and `ea` are zero.
- R2: A write takes effect only when `cs` and `we` are high and `addr[19:4]` equals 0x0001, which is the window 0x10..0x1F. `rdata` is zero unless `cs` and `re` are high with `addr` inside that window.
- R3: The window slot is `addr[3:0]`, with this map:
  - 0 and 1 hold the PC low and high parts.
  - 2+2k and 3+2k hold the low and high parts of stack pointer k, for k = 0..2.
  - 8 and 9 hold Y low and high. 10 and 11 hold Z low and high.
  - 12 holds the Y offset and 13 holds the Z offset.
  - A high-part write stores `wdata[3:0]`, and a high-part read returns those 4 bits zero-extended.
  - Slots 14 and 15 read zero and ignore writes.
- R4: In each cycle with `pc_adv` high, the PC increases by `pc_step` (0..3), modulo 2^20.
- R5: Stack pointer k increases by one when only `sp_inc[k]` is high and decreases by one when only `sp_dec[k]` is high, modulo 2^20. It holds when both or neither of these inputs are high.
- R6: A bus write to a pointer's low or high slot in the same cycle as a PC advance or stack step of that pointer wins. The written part takes the bus data, and the other part keeps its old value.
- R7: The base of the effective address is Y when `sel_y` is high. Otherwise it is Z when `sel_z` is high, and otherwise it is zero. With `ofs_add` low, `ea` equals that base.
- R8: With `ofs_add` high, `ea` is the base plus the zero-extended offset of the selected index (Y offset with Y, Z offset with Z), modulo 2^20. With no index selected, `ea` stays zero.
- R9: A read returns the register contents in the same cycle as the access, without a wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select for the access interface |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| addr | input | 20 | Data address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| pc_adv | input | 1 | Advance the program counter this cycle |
| pc_step | input | 2 | Advance amount, 0..3 |
| sp_inc | input | 3 | Per stack pointer increment request |
| sp_dec | input | 3 | Per stack pointer decrement request |
| sel_y | input | 1 | Select index Y for address generation |
| sel_z | input | 1 | Select index Z for address generation |
| ofs_add | input | 1 | Add the selected offset to the index |
| pc_q | output | 20 | Program counter value |
| sp_q | output | 60 | Stack pointers, pointer k at bits 20k+19..20k |
| ea | output | 20 | Effective address |

## Verification
Some properties are checked on every cycle:
- A low-part or high-part write lands in the next cycle.
- A step with no write moves a pointer by exactly its delta.
- A pointer with neither a write nor a step holds its value.
- An idle or out-of-window access drives `rdata` to zero.
- With no offset requested, the selected index passes to `ea` unchanged.

Only the bench scenarios can show the rest:
- The slot map as a whole.
- Write rejection at the window edges.
- Wrap at 2^20 in both directions.
- Step-versus-write priority on real pointers.
- Offset sums that carry past bit 19.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int PTR_W  = 20;
  localparam int DATA_W = 16;
  localparam int HI_W   = PTR_W - DATA_W;
  localparam int NUM_SP = 3;

  localparam logic [3:0] SLOT_PC_LO = 4'd0;
  localparam logic [3:0] SLOT_PC_HI = 4'd1;
  localparam logic [3:0] SLOT_SP0   = 4'd2;
  localparam logic [3:0] SLOT_Y_LO  = 4'd8;
  localparam logic [3:0] SLOT_Y_HI  = 4'd9;
  localparam logic [3:0] SLOT_Z_LO  = 4'd10;
  localparam logic [3:0] SLOT_Z_HI  = 4'd11;
  localparam logic [3:0] SLOT_OFS_Y = 4'd12;
  localparam logic [3:0] SLOT_OFS_Z = 4'd13;
endpackage

// File: rtl/ptr_rst_sync.sv
module ptr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/ptr_cnt.sv
module ptr_cnt #(
  parameter int PW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          step_en,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] q
);
  localparam int HW = PW - DW;

  logic [PW-1:0] q_d;
  logic          en;

  assign en = wr_lo | wr_hi | step_en;

  always_comb begin
    q_d = q;
    if (wr_lo)        q_d = {q[PW-1:DW], wdata};
    else if (wr_hi)   q_d = {wdata[HW-1:0], q[DW-1:0]};
    else if (step_en) q_d = q + step;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (en)  q <= q_d;
  end

  assert_lo_write_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_lo |=> (q[DW-1:0] == $past(wdata)) && (q[PW-1:DW] == $past(q[PW-1:DW])));

  assert_hi_write_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_hi && !wr_lo) |=> (q[PW-1:DW] == $past(wdata[HW-1:0])) && (q[DW-1:0] == $past(q[DW-1:0])));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_en && !wr_lo && !wr_hi) |=> (q == $past(q) + $past(step)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!step_en && !wr_lo && !wr_hi) |=> $stable(q));
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int PW = 20,
  parameter int DW = 16
) (
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  input  logic [DW-1:0] ofs_y,
  input  logic [DW-1:0] ofs_z,
  input  logic          sel_y,
  input  logic          sel_z,
  input  logic          ofs_add,
  output logic [PW-1:0] ea
);
  logic [PW-1:0] base;
  logic [DW-1:0] ofs;
  logic [PW-1:0] sum;

  always_comb begin
    base = '0;
    ofs  = '0;
    if (sel_y) begin
      base = y;
      ofs  = ofs_y;
    end else if (sel_z) begin
      base = z;
      ofs  = ofs_z;
    end
  end

  assign sum = base + {{(PW-DW){1'b0}}, ofs};
  assign ea  = ofs_add ? sum : base;
endmodule

// File: rtl/ptr_reg_unit.sv
module ptr_reg_unit
  import ptr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    we,
  input  logic                    re,
  input  logic [PTR_W-1:0]        addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic                    pc_adv,
  input  logic [1:0]              pc_step,
  input  logic [NUM_SP-1:0]       sp_inc,
  input  logic [NUM_SP-1:0]       sp_dec,
  input  logic                    sel_y,
  input  logic                    sel_z,
  input  logic                    ofs_add,
  output logic [PTR_W-1:0]        pc_q,
  output logic [NUM_SP*PTR_W-1:0] sp_q,
  output logic [PTR_W-1:0]        ea
);
  localparam int NSLOT = 16;

  logic             rst_n_s;
  logic             hit;
  logic             wr;
  logic [3:0]       slot;
  logic [NSLOT-1:0] wr_slot;
  logic [PTR_W-1:0] y_q;
  logic [PTR_W-1:0] z_q;
  logic [DATA_W-1:0] ofs_y_q, ofs_y_d;
  logic [DATA_W-1:0] ofs_z_q, ofs_z_d;

  ptr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign hit  = (addr[PTR_W-1:4] == {{(PTR_W-5){1'b0}}, 1'b1});
  assign slot = addr[3:0];
  assign wr   = cs & we & hit;

  always_comb begin
    wr_slot = '0;
    if (wr) wr_slot[slot] = 1'b1;
  end

  ptr_cnt #(.PW(PTR_W), .DW(DATA_W)) u_pc (
    .clk(clk), .rst_ni(rst_n_s),
    .wr_lo(wr_slot[SLOT_PC_LO]), .wr_hi(wr_slot[SLOT_PC_HI]), .wdata(wdata),
    .step_en(pc_adv), .step({{(PTR_W-2){1'b0}}, pc_step}), .q(pc_q)
  );

  for (genvar k = 0; k < NUM_SP; k++) begin : g_sp
    localparam int LO = int'(SLOT_SP0) + 2*k;
    logic             s_en;
    logic [PTR_W-1:0] s_step;
    assign s_en   = sp_inc[k] ^ sp_dec[k];
    assign s_step = sp_inc[k] ? {{(PTR_W-1){1'b0}}, 1'b1} : {PTR_W{1'b1}};
    ptr_cnt #(.PW(PTR_W), .DW(DATA_W)) u_sp (
      .clk(clk), .rst_ni(rst_n_s),
      .wr_lo(wr_slot[LO]), .wr_hi(wr_slot[LO+1]), .wdata(wdata),
      .step_en(s_en), .step(s_step), .q(sp_q[k*PTR_W +: PTR_W])
    );
  end

  ptr_cnt #(.PW(PTR_W), .DW(DATA_W)) u_y (
    .clk(clk), .rst_ni(rst_n_s),
    .wr_lo(wr_slot[SLOT_Y_LO]), .wr_hi(wr_slot[SLOT_Y_HI]), .wdata(wdata),
    .step_en(1'b0), .step('0), .q(y_q)
  );

  ptr_cnt #(.PW(PTR_W), .DW(DATA_W)) u_z (
    .clk(clk), .rst_ni(rst_n_s),
    .wr_lo(wr_slot[SLOT_Z_LO]), .wr_hi(wr_slot[SLOT_Z_HI]), .wdata(wdata),
    .step_en(1'b0), .step('0), .q(z_q)
  );

  always_comb begin
    ofs_y_d = wr_slot[SLOT_OFS_Y] ? wdata : ofs_y_q;
    ofs_z_d = wr_slot[SLOT_OFS_Z] ? wdata : ofs_z_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ofs_y_q <= '0;
      ofs_z_q <= '0;
    end else begin
      if (wr_slot[SLOT_OFS_Y]) ofs_y_q <= ofs_y_d;
      if (wr_slot[SLOT_OFS_Z]) ofs_z_q <= ofs_z_d;
    end
  end

  ptr_agu #(.PW(PTR_W), .DW(DATA_W)) u_agu (
    .y(y_q), .z(z_q), .ofs_y(ofs_y_q), .ofs_z(ofs_z_q),
    .sel_y(sel_y), .sel_z(sel_z), .ofs_add(ofs_add), .ea(ea)
  );

  // Read path: combinational, same-cycle (R9)
  always_comb begin
    rdata = '0;
    if (cs && re && hit) begin
      unique case (slot)
        SLOT_PC_LO: rdata = pc_q[DATA_W-1:0];
        SLOT_PC_HI: rdata = {{(DATA_W-HI_W){1'b0}}, pc_q[PTR_W-1:DATA_W]};
        SLOT_Y_LO:  rdata = y_q[DATA_W-1:0];
        SLOT_Y_HI:  rdata = {{(DATA_W-HI_W){1'b0}}, y_q[PTR_W-1:DATA_W]};
        SLOT_Z_LO:  rdata = z_q[DATA_W-1:0];
        SLOT_Z_HI:  rdata = {{(DATA_W-HI_W){1'b0}}, z_q[PTR_W-1:DATA_W]};
        SLOT_OFS_Y: rdata = ofs_y_q;
        SLOT_OFS_Z: rdata = ofs_z_q;
        4'd2, 4'd4, 4'd6: rdata = sp_q[((int'(slot)-2)/2)*PTR_W +: DATA_W];
        4'd3, 4'd5, 4'd7: rdata = {{(DATA_W-HI_W){1'b0}},
                                   sp_q[((int'(slot)-3)/2)*PTR_W + DATA_W +: HI_W]};
        default:    rdata = '0;
      endcase
    end
  end

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cs && re && hit) |-> (rdata == '0));

  assert_ea_base_y_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_y && !ofs_add) |-> (ea == y_q));

  assert_ea_base_z_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sel_y && sel_z && !ofs_add) |-> (ea == z_q));

  assert_ea_none_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sel_y && !sel_z) |-> (ea == '0));
endmodule

// File: tb/ptr_reg_unit_test.sv
`timescale 1ns/1ps
module ptr_reg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, we = 0, re = 0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pc_adv = 0;
  logic [1:0]  pc_step = '0;
  logic [2:0]  sp_inc = '0, sp_dec = '0;
  logic        sel_y = 0, sel_z = 0, ofs_add = 0;
  logic [19:0] pc_q;
  logic [59:0] sp_q;
  logic [19:0] ea;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [19:0] m_pc, m_y, m_z;
  logic [19:0] m_sp [3];
  logic [15:0] m_oy, m_oz;

  always #10 clk = ~clk;

  ptr_reg_unit uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pc_adv(pc_adv), .pc_step(pc_step),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .sel_y(sel_y), .sel_z(sel_z),
    .ofs_add(ofs_add), .pc_q(pc_q), .sp_q(sp_q), .ea(ea)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_slot(input int s);
    case (s)
      0: return m_pc[15:0];
      1: return {12'h0, m_pc[19:16]};
      2, 4, 6: return m_sp[(s-2)/2][15:0];
      3, 5, 7: return {12'h0, m_sp[(s-3)/2][19:16]};
      8: return m_y[15:0];
      9: return {12'h0, m_y[19:16]};
      10: return m_z[15:0];
      11: return {12'h0, m_z[19:16]};
      12: return m_oy;
      13: return m_oz;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_write(input int s, input logic [15:0] d);
    case (s)
      0: m_pc[15:0] = d;
      1: m_pc[19:16] = d[3:0];
      2, 4, 6: m_sp[(s-2)/2][15:0] = d;
      3, 5, 7: m_sp[(s-3)/2][19:16] = d[3:0];
      8: m_y[15:0] = d;
      9: m_y[19:16] = d[3:0];
      10: m_z[15:0] = d;
      11: m_z[19:16] = d[3:0];
      12: m_oy = d;
      13: m_oz = d;
      default: ;
    endcase
  endtask

  // one-cycle access, inputs driven on the falling edge
  task automatic bus_write(input logic [19:0] a, input logic [15:0] d, input logic c);
    @(negedge clk);
    cs = c; we = 1; re = 0; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; we = 0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [15:0] d);
    @(negedge clk);
    cs = 1; re = 1; we = 0; addr = a;
    #2 d = rdata;
    cs = 0; re = 0;
  endtask

  task automatic pc_tick(input logic [1:0] st);
    @(negedge clk);
    pc_adv = 1; pc_step = st;
    @(negedge clk);
    pc_adv = 0;
    m_pc = m_pc + 20'(st);
  endtask

  task automatic sp_tick(input logic [2:0] inc, input logic [2:0] dec);
    @(negedge clk);
    sp_inc = inc; sp_dec = dec;
    @(negedge clk);
    sp_inc = 0; sp_dec = 0;
    for (int k = 0; k < 3; k++)
      if (inc[k] && !dec[k]) m_sp[k] = m_sp[k] + 20'd1;
      else if (dec[k] && !inc[k]) m_sp[k] = m_sp[k] - 20'd1;
  endtask

  task automatic check_all(input string req);
    logic [15:0] d;
    for (int s = 0; s < 16; s++) begin
      bus_read(20'h00010 | 20'(s), d);
      check(req, {16'h0, d}, {16'h0, exp_slot(s)});
    end
    check(req, {12'h0, pc_q}, {12'h0, m_pc});
    for (int k = 0; k < 3; k++) check(req, {12'h0, sp_q[k*20 +: 20]}, {12'h0, m_sp[k]});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [19:0] base, e;
    m_pc = 0; m_y = 0; m_z = 0; m_oy = 0; m_oz = 0;
    for (int k = 0; k < 3; k++) m_sp[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_all("R1");
    check("R1", {12'h0, ea}, 32'h0);

    // R3/R9: write every slot, read all back in the access cycle
    for (int s = 0; s < 16; s++) begin
      logic [15:0] v;
      v = 16'((s + 1) * 16'h1357) ^ 16'hA5C3;
      bus_write(20'h00010 | 20'(s), v, 1'b1);
      model_write(s, v);
    end
    check_all("R3");

    // R2: outside the window and with cs low, writes are ignored
    for (int s = 0; s < 16; s++) begin
      bus_write(20'h00000 | 20'(s), 16'hFFFF, 1'b1);
      bus_write(20'h00020 | 20'(s), 16'hFFFF, 1'b1);
      bus_write(20'h10010 | 20'(s), 16'hFFFF, 1'b1);
      bus_write(20'h00010 | 20'(s), 16'hFFFF, 1'b0);
    end
    check_all("R2");
    bus_read(20'h00020, d);
    check("R2 read outside", {16'h0, d}, 32'h0);
    @(negedge clk); cs = 1; re = 0; addr = 20'h00010; #2;
    check("R2 read re low", {16'h0, rdata}, 32'h0);
    cs = 0;

    // R4: PC step sweep and wrap
    bus_write(20'h00010, 16'h0000, 1); model_write(0, 16'h0000);
    bus_write(20'h00011, 16'h0000, 1); model_write(1, 16'h0000);
    for (int r = 0; r < 3; r++)
      for (int st = 0; st < 4; st++) begin
        pc_tick(2'(st));
        check("R4", {12'h0, pc_q}, {12'h0, m_pc});
      end
    bus_write(20'h00010, 16'hFFFE, 1); model_write(0, 16'hFFFE);
    bus_write(20'h00011, 16'h000F, 1); model_write(1, 16'h000F);
    pc_tick(2'd3);
    check("R4 wrap", {12'h0, pc_q}, 32'h00001);

    // R5: stack pointers up, down, both, wrap
    for (int k = 0; k < 3; k++) begin
      bus_write(20'h00012 + 20'(2*k), 16'h0000, 1); model_write(2+2*k, 16'h0);
      bus_write(20'h00013 + 20'(2*k), 16'h0000, 1); model_write(3+2*k, 16'h0);
    end
    sp_tick(3'b001, 3'b000);
    sp_tick(3'b011, 3'b010);
    sp_tick(3'b000, 3'b100);
    for (int k = 0; k < 3; k++) check("R5", {12'h0, sp_q[k*20 +: 20]}, {12'h0, m_sp[k]});
    check("R5 wrap down", {12'h0, sp_q[40 +: 20]}, 32'hFFFFF);
    sp_tick(3'b100, 3'b000);
    check("R5 wrap up", {12'h0, sp_q[40 +: 20]}, 32'h00000);
    for (int i = 0; i < 5; i++) sp_tick(3'b010, 3'b001);
    check_all("R5");

    // R6: write beats a step in the same cycle
    @(negedge clk);
    pc_adv = 1; pc_step = 2'd2; cs = 1; we = 1; addr = 20'h00010; wdata = 16'h4321;
    sp_inc = 3'b010; 
    @(negedge clk);
    pc_adv = 0; cs = 0; we = 0; sp_inc = 0;
    m_pc[15:0] = 16'h4321; m_sp[1] = m_sp[1] + 1;
    check("R6 pc", {12'h0, pc_q}, {12'h0, m_pc});
    @(negedge clk);
    sp_dec = 3'b001; cs = 1; we = 1; addr = 20'h00013; wdata = 16'hFFF7;
    @(negedge clk);
    sp_dec = 0; cs = 0; we = 0;
    m_sp[0][19:16] = 4'h7;
    check("R6 sp", {12'h0, sp_q[19:0]}, {12'h0, m_sp[0]});

    // R7/R8: address generation sweep
    bus_write(20'h00018, 16'hFFF0, 1); model_write(8, 16'hFFF0);
    bus_write(20'h00019, 16'h000F, 1); model_write(9, 16'h000F);
    bus_write(20'h0001A, 16'h1200, 1); model_write(10, 16'h1200);
    bus_write(20'h0001B, 16'h0003, 1); model_write(11, 16'h0003);
    bus_write(20'h0001C, 16'h0020, 1); model_write(12, 16'h0020);
    bus_write(20'h0001D, 16'hF00F, 1); model_write(13, 16'hF00F);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      sel_y = c[0]; sel_z = c[1]; ofs_add = c[2];
      #2;
      base = c[0] ? m_y : (c[1] ? m_z : 20'h0);
      e = base;
      if (c[2] && c[0]) e = base + {4'h0, m_oy};
      else if (c[2] && c[1]) e = base + {4'h0, m_oz};
      check(c[2] ? "R8" : "R7", {12'h0, ea}, {12'h0, e});
    end
    sel_y = 0; sel_z = 0; ofs_add = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule